// File: doc/BRIEF.md
# Comparator Edge Flag Status Register

This block is a byte-wide status and control register that watches the digital output of an analog comparator. The comparator level comes in with no timing relation to the clock. The block passes it through a two-flop synchronizer and compares each synchronized sample with the one before it to find edges. A rising transition and a falling transition each set their own sticky flag. Software clears a flag by writing a one to that flag's bit.

Each flag has its own interrupt enable. The block ORs the two enabled flags into a single registered interrupt request. When the DMA enable bit is set, either flag raises a registered DMA request. A DMA acknowledge pulse that arrives while DMA is enabled clears both flags. Reads are combinational. They return the control bits, both flags and the current synchronized comparator level.

Top module: `cmp_edge_status`

## Requirements
- R1: After reset, every register bit is 0 and `irq` and `dma_req` are 0. `reg_rdata` is 0 while `cmp_level` is held low.
- R2: Bits 7 and 5 of `reg_rdata` always read 0. Writes to those bits have no effect.
- R3: The control bits are DMA enable (bit 6), rising interrupt enable (bit 4) and falling interrupt enable (bit 3). Each is loaded from `reg_wdata` on a write and reads back the value written.
- R4: Bit 0 returns the synchronized comparator level, two clock edges after `cmp_level` changes. Writes do not change bit 0.
- R5: A 0-to-1 change of the synchronized level sets the rising flag (bit 2) one clock later. The flag then stays 1 until it is cleared.
- R6: A 1-to-0 change of the synchronized level sets the falling flag (bit 1) one clock later. The flag then stays 1 until it is cleared.
- R7: Writing 1 to bit 2 or bit 1 clears that flag. Writing 0 to a flag bit leaves the flag unchanged.
- R8: If a new edge and a clear of the same flag fall in the same cycle, the flag ends at 1.
- R9: `irq` is 1 one clock after (rising flag AND bit 4) OR (falling flag AND bit 3) is true, and 0 one clock after it is false.
- R10: `dma_req` is 1 one clock after bit 6 is 1 and at least one flag is 1, and 0 one clock after that condition ends.
- R11: A `dma_ack` pulse clears both flags when bit 6 is 1. It has no effect when bit 6 is 0. A new edge in the same cycle still sets its flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| cmp_level | input | 1 | Asynchronous comparator output |
| dma_ack | input | 1 | DMA acknowledge pulse |
| irq | output | 1 | Registered interrupt request |
| dma_req | output | 1 | Registered DMA request |

## Verification
Three things can meet the same flag in one cycle: setting it from a detected edge, clearing it by a software write of one, and clearing it by a DMA acknowledge. The bench counts the three synchronizer and detector edges from a level change and places the clearing write on the exact edge where the flag is set. It then requires the flag to read 1, as R8 states. A second run does the same with an acknowledge against a new edge. The bench also checks that a zero written to a flag bit, and an acknowledge sent while DMA is disabled, leave the flags as they were.

// File: rtl/cesr_pkg.sv
package cesr_pkg;
  localparam int REG_W     = 8;
  localparam int SYNC_LEN  = 2;
  localparam int N_EDGE    = 2;   // index 1 = rising, index 0 = falling
  localparam int B_DMAEN   = 6;
  localparam int B_RIE     = 4;
  localparam int B_FIE     = 3;
  localparam int B_RFLG    = 2;
  localparam int B_FFLG    = 1;
  localparam int B_LVL     = 0;

  typedef struct packed {
    logic              dma_en;
    logic [N_EDGE-1:0] ie;     // {rise_ie, fall_ie}
  } ctrl_t;

  function automatic logic irq_of(logic [N_EDGE-1:0] flg, logic [N_EDGE-1:0] ie);
    return |(flg & ie);
  endfunction

  function automatic logic dma_of(logic en, logic [N_EDGE-1:0] flg);
    return en & (|flg);
  endfunction

  function automatic logic [REG_W-1:0] pack_status(ctrl_t c, logic [N_EDGE-1:0] flg, logic lvl);
    logic [REG_W-1:0] v;
    v           = '0;
    v[B_DMAEN]  = c.dma_en;
    v[B_RIE]    = c.ie[1];
    v[B_FIE]    = c.ie[0];
    v[B_RFLG]   = flg[1];
    v[B_FFLG]   = flg[0];
    v[B_LVL]    = lvl;
    return v;
  endfunction
endpackage

// File: rtl/cesr_sync.sv
module cesr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cesr_edge.sv
module cesr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  // R5/R6: a detected edge is followed by the previous sample matching the new level
  p_edge_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise || fall) |=> (prev == $past(lvl)));
endmodule

// File: rtl/cesr_flags.sv
module cesr_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag[i] <= 1'b0;
      else if (set[i]) flag[i] <= 1'b1;
      else if (clr[i]) flag[i] <= 1'b0;
    end

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flag[i]);
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !flag[i]);
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!set[i] && !clr[i]) |=> $stable(flag[i]));
  end
endmodule

// File: rtl/cmp_edge_status.sv
module cmp_edge_status
  import cesr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             cmp_level,
  input  logic             dma_ack,
  output logic             irq,
  output logic             dma_req
);
  ctrl_t             ctrl;
  logic              lvl_sync;
  logic              rise_evt, fall_evt;
  logic [N_EDGE-1:0] set_vec, clr_vec, flg;
  logic              ack_hit;

  cesr_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_level), .q(lvl_sync));

  cesr_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_sync), .rise(rise_evt), .fall(fall_evt));

  assign set_vec = {rise_evt, fall_evt};
  assign ack_hit = dma_ack & ctrl.dma_en;
  assign clr_vec = ({N_EDGE{reg_we}} & reg_wdata[B_RFLG:B_FFLG]) | {N_EDGE{ack_hit}};

  cesr_flags #(.N(N_EDGE)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(set_vec), .clr(clr_vec), .flag(flg));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      irq     <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      if (reg_we) begin
        ctrl.dma_en <= reg_wdata[B_DMAEN];
        ctrl.ie     <= {reg_wdata[B_RIE], reg_wdata[B_FIE]};
      end
      irq     <= irq_of(flg, ctrl.ie);
      dma_req <= dma_of(ctrl.dma_en, flg);
    end
  end

  assign reg_rdata = pack_status(ctrl, flg, lvl_sync);

  p_rise_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl_sync) |=> flg[1]);
  p_fall_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lvl_sync) |=> flg[0]);
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|(flg & ctrl.ie)));
  p_dma_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(ctrl.dma_en));
  p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !rise_evt && !fall_evt) |=> (flg == '0));
  p_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7] == 1'b0) && (reg_rdata[5] == 1'b0));
endmodule

// File: tb/cmp_edge_status_tb.sv
module cmp_edge_status_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       cmp_level = 1'b0;
  logic       dma_ack = 1'b0;
  logic       irq, dma_req;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_edge_status u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cmp_level(cmp_level), .dma_ack(dma_ack),
    .irq(irq), .dma_req(dma_req));

  // {write, wdata, level, exp_rdata, exp_irq, exp_dma}
  localparam logic [19:0] VEC [0:7] = '{
    {1'b1, 8'h18, 1'b0, 8'h18, 1'b0, 1'b0},  // R3 enables
    {1'b0, 8'h00, 1'b1, 8'h1D, 1'b1, 1'b0},  // R5 R9 rising
    {1'b1, 8'h1C, 1'b1, 8'h19, 1'b0, 1'b0},  // R7 clear rising
    {1'b0, 8'h00, 1'b0, 8'h1A, 1'b1, 1'b0},  // R6 R9 falling
    {1'b1, 8'h40, 1'b0, 8'h42, 1'b0, 1'b1},  // R10 dma on
    {1'b0, 8'h00, 1'b1, 8'h47, 1'b0, 1'b1},  // R5 R4 both flags
    {1'b1, 8'hE6, 1'b1, 8'h41, 1'b0, 1'b0},  // R2 R7 reserved, clear both
    {1'b1, 8'h10, 1'b0, 8'h12, 1'b0, 1'b0}   // R9 disabled fall enable
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic ack_pulse();
    dma_ack = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0;
  endtask

  initial begin
    tick(20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1 rdata", reg_rdata, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 dma", {7'b0, dma_req}, 8'h00);

    for (int i = 0; i < 8; i++) begin
      cmp_level = VEC[i][10];
      if (VEC[i][19]) wr(VEC[i][18:11]); else tick(1);
      tick(3);
      chk($sformatf("R3-vec%0d rdata", i), reg_rdata, VEC[i][9:2]);
      chk($sformatf("R9 vec%0d irq", i), {7'b0, irq}, {7'b0, VEC[i][1]});
      chk($sformatf("R10 vec%0d dma", i), {7'b0, dma_req}, {7'b0, VEC[i][0]});
    end

    // R9 latency: flag after 3 edges, irq one edge later
    wr(8'h12);
    cmp_level = 1'b1;
    tick(1);
    chk("R4 level not yet", {7'b0, reg_rdata[0]}, 8'h00);
    tick(1);
    chk("R4 level synced", {7'b0, reg_rdata[0]}, 8'h01);
    tick(1);
    chk("R5 flag set", {7'b0, reg_rdata[2]}, 8'h01);
    chk("R9 irq lag", {7'b0, irq}, 8'h00);
    tick(1);
    chk("R9 irq up", {7'b0, irq}, 8'h01);

    // R8 collision of set and write-one clear
    wr(8'h14);
    tick(1);
    chk("R9 irq drop", {7'b0, irq}, 8'h00);
    cmp_level = 1'b0;
    tick(4);
    cmp_level = 1'b1;
    tick(2);
    wr(8'h14);
    chk("R8 set wins", {7'b0, reg_rdata[2]}, 8'h01);
    wr(8'h10);
    chk("R7 write zero keeps", {7'b0, reg_rdata[2]}, 8'h01);
    wr(8'h14);
    chk("R7 write one clears", {7'b0, reg_rdata[2]}, 8'h00);

    // R11 acknowledge with DMA enabled
    wr(8'h46);
    cmp_level = 1'b0;
    tick(4);
    chk("R10 dma up", {7'b0, dma_req}, 8'h01);
    ack_pulse();
    chk("R11 ack clears", {6'b0, reg_rdata[2:1]}, 8'h00);
    tick(1);
    chk("R10 dma drop", {7'b0, dma_req}, 8'h00);

    // R11 acknowledge against a new edge
    cmp_level = 1'b1;
    tick(2);
    ack_pulse();
    chk("R11 edge beats ack", {6'b0, reg_rdata[2:1]}, 8'h02);

    // R11 acknowledge ignored with DMA disabled
    wr(8'h06);
    cmp_level = 1'b0;
    tick(4);
    ack_pulse();
    chk("R11 ack ignored", {6'b0, reg_rdata[2:1]}, 8'h01);

    // R4 R2 read-only level and reserved bits
    wr(8'hA1);
    chk("R4 R2 readonly", reg_rdata, 8'h02);

    $display("  test done: total=%0d bad=%0d", total, bad);
    done = 1;
    $finish;
  end
endmodule